// File: doc/BRIEF.md
# Squared-Difference Accumulating Processing Element

This block is a compute element for a neural-network accelerator. It scores each activation/weight pair by how far apart they are instead of by their product. For every accepted pair of signed 8-bit operands it takes the difference and squares it. The squares are summed over a kernel window. At the end of the window the block returns minus one half of that sum. A network trained for this distance-style similarity runs on the block in the place where a multiply-accumulate element would otherwise sit.

The squarer is not a general multiplier. It takes the unsigned magnitude of the difference. Each diagonal product of a bit with itself collapses to the bit. Each cross product of two different bits is formed once and placed one column higher, which doubles it. The resulting rows are summed by a chain of ripple adders, each built from a half adder and then full adders.

Operands arrive on a valid/ready stream whose last flag closes a window. A clear pulse throws away a partial window. The result leaves on its own valid/ready pair. The next window can begin on the cycle the previous result is taken.

Top module: `sqdiff_pe`

## Requirements
- R1: A window's result equals floor(-S/2), where S is the sum of (act - wgt)² over every beat accepted in that window, with operands read as signed integers.
- R2: Operands are 8-bit two's complement. Extreme pairs such as -128 and 127 contribute 65025 with no wrap, so a single such beat yields -32513.
- R3: `out_valid` is high on the cycle after the beat with `in_last` high is accepted. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_result` holds its value. No result appears without a preceding last beat.
- R4: While a result waits (`out_valid` high, `out_ready` low), `in_ready` is low. No beat is lost or counted twice across a stall.
- R5: While `clear` is high, `in_ready` is low and the partial window is discarded. Beats accepted before the clear do not appear in any later result.
- R6: Windows of any length from 1 to MAX_WIN (default 4096) give exact results. A 4096-beat window with every difference at ±255 returns -133171200.
- R7: After a result is produced, the next window starts from zero. Back-to-back windows are independent.
- R8: Cycles with `in_valid` low add nothing to the sum, whatever the operand and last inputs carry.
- R9: After reset, `out_valid` is low and `in_ready` is high (with `clear` low).
- R10: Every result is zero or negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Discards the partial window |
| in_valid | input | 1 | Operand beat present |
| in_ready | output | 1 | Block accepts a beat this cycle |
| in_act | input | OPND_W | Signed activation operand |
| in_wgt | input | OPND_W | Signed weight operand |
| in_last | input | 1 | Beat closes the window |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_result | output | ACC_W | Signed window result, -S/2 rounded down |

## Verification
Assertions check the handshake on every cycle. A result must follow a last beat by one cycle and must hold steady under back-pressure. Input is blocked during a stall or a clear, results are never positive, and a window never outgrows MAX_WIN. The arithmetic can only be shown by the bench scenarios, which compare results against a wide-integer reference. These scenarios cover extreme operands, odd sums, zero-difference windows, gaps in the input, a discarded partial window, a result held across a stall, and the longest window.

// File: rtl/sqd_pkg.sv
package sqd_pkg;

    localparam int unsigned DEF_OPND_W  = 8;
    localparam int unsigned DEF_MAX_WIN = 4096;

    // Control handed from the stream edge to the window accumulator
    typedef struct packed {
        logic clr;
        logic fire;
        logic last;
    } acc_ctrl_t;

    // Square width plus window growth plus a sign bit
    function automatic int unsigned acc_bits(input int unsigned opnd_w,
                                             input int unsigned max_win);
        return 2 * opnd_w + $clog2(max_win) + 1;
    endfunction

endpackage

// File: rtl/sqd_ripple_add.sv
module sqd_ripple_add #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s
);
    logic [W-2:0] cy;

    for (genvar k = 0; k < W; k++) begin : g_cell
        if (k == 0) begin : g_half
            assign s[k]  = a[k] ^ b[k];
            assign cy[k] = a[k] & b[k];
        end else if (k == W - 1) begin : g_top
            assign s[k] = a[k] ^ b[k] ^ cy[k-1];
        end else begin : g_full
            assign s[k]  = a[k] ^ b[k] ^ cy[k-1];
            assign cy[k] = (a[k] & b[k]) | (cy[k-1] & (a[k] ^ b[k]));
        end
    end
endmodule

// File: rtl/sqd_operand_stage.sv
module sqd_operand_stage #(
    parameter int unsigned N = 8
) (
    input  logic signed [N-1:0] act,
    input  logic signed [N-1:0] wgt,
    output logic        [N-1:0] mag
);
    logic [N:0] diff;

    assign diff = {act[N-1], act} - {wgt[N-1], wgt};
    // |diff| <= 2^N - 1, so the low N bits carry the whole magnitude
    assign mag  = diff[N] ? (~diff[N-1:0] + {{(N-1){1'b0}}, 1'b1})
                          : diff[N-1:0];
endmodule

// File: rtl/sqd_folded_squarer.sv
module sqd_folded_squarer #(
    parameter  int unsigned N   = 8,
    localparam int unsigned P_W = 2 * N
) (
    input  logic [N-1:0]   mag,
    output logic [P_W-1:0] square
);
    logic [P_W-1:0] row  [N];
    logic [P_W-1:0] psum [N];

    // Row i: bit i alone at column 2i, cross terms i*j (j > i) at column i+j+1
    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar b = 0; b < P_W; b++) begin : g_bit
            if (b == 2 * i) begin : g_diag
                assign row[i][b] = mag[i];
            end else if (b > 2 * i + 1 && b <= i + N) begin : g_cross
                assign row[i][b] = mag[i] & mag[b-i-1];
            end else begin : g_zero
                assign row[i][b] = 1'b0;
            end
        end
    end

    assign psum[0] = row[0];
    for (genvar i = 1; i < N; i++) begin : g_sum
        sqd_ripple_add #(.W(P_W)) u_add (
            .a (psum[i-1]),
            .b (row[i]),
            .s (psum[i])
        );
    end

    assign square = psum[N-1];
endmodule

// File: rtl/sqd_window_acc.sv
module sqd_window_acc
    import sqd_pkg::*;
#(
    parameter int unsigned SQ_W  = 16,
    parameter int unsigned ACC_W = 29
) (
    input  logic                    clk,
    input  logic                    rst,
    input  acc_ctrl_t               ctrl,
    input  logic [SQ_W-1:0]         square,
    input  logic                    out_ready,
    output logic                    res_valid,
    output logic signed [ACC_W-1:0] res
);
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] sum_next;
    logic signed [ACC_W-1:0] neg_sum;
    logic signed [ACC_W-1:0] half_neg;

    assign sum_next = acc + $signed({{(ACC_W-SQ_W){1'b0}}, square});
    assign neg_sum  = -sum_next;
    assign half_neg = neg_sum >>> 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc       <= '0;
            res_valid <= 1'b0;
            res       <= '0;
        end else begin
            if (res_valid && out_ready) begin
                res_valid <= 1'b0;
            end
            if (ctrl.clr) begin
                acc <= '0;
            end else if (ctrl.fire) begin
                if (ctrl.last) begin
                    acc       <= '0;
                    res       <= half_neg;
                    res_valid <= 1'b1;
                end else begin
                    acc <= sum_next;
                end
            end
        end
    end
endmodule

// File: rtl/sqdiff_pe.sv
module sqdiff_pe
    import sqd_pkg::*;
#(
    parameter  int unsigned OPND_W  = DEF_OPND_W,
    parameter  int unsigned MAX_WIN = DEF_MAX_WIN,
    localparam int unsigned SQ_W    = 2 * OPND_W,
    localparam int unsigned ACC_W   = acc_bits(OPND_W, MAX_WIN)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clear,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic signed [OPND_W-1:0] in_act,
    input  logic signed [OPND_W-1:0] in_wgt,
    input  logic                     in_last,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic signed [ACC_W-1:0]  out_result
);
    logic [OPND_W-1:0] mag;
    logic [SQ_W-1:0]   square;
    acc_ctrl_t         ctrl;

    assign in_ready  = !clear && !(out_valid && !out_ready);
    assign ctrl.clr  = clear;
    assign ctrl.fire = in_valid && in_ready;
    assign ctrl.last = in_last;

    sqd_operand_stage #(.N(OPND_W)) u_opnd (
        .act (in_act),
        .wgt (in_wgt),
        .mag (mag)
    );

    sqd_folded_squarer #(.N(OPND_W)) u_sq (
        .mag    (mag),
        .square (square)
    );

    sqd_window_acc #(.SQ_W(SQ_W), .ACC_W(ACC_W)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .square    (square),
        .out_ready (out_ready),
        .res_valid (out_valid),
        .res       (out_result)
    );
endmodule

// File: rtl/sqd_pe_checker.sv
module sqd_pe_checker #(
    parameter int unsigned ACC_W   = 29,
    parameter int unsigned MAX_WIN = 4096
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    clear,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic                    in_last,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic signed [ACC_W-1:0] out_result
);
    localparam int unsigned CNT_W = $clog2(MAX_WIN) + 1;

    logic             fire;
    logic [CNT_W-1:0] beats;

    assign fire = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst || clear || (fire && in_last)) beats <= '0;
        else if (fire)                         beats <= beats + 1'b1;
    end

    AST_VALID_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        fire && in_last |=> out_valid);                                   // R3
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_result));    // R3
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(fire && in_last) || $past(out_valid && !out_ready)); // R3
    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !in_ready);                           // R4
    AST_CLEAR_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        clear |-> !in_ready);                                             // R5
    AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (rst)
        fire |-> beats < CNT_W'(MAX_WIN));                                // R6
    AST_RESULT_NONPOS: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_result <= 0);                                   // R10
endmodule

bind sqdiff_pe sqd_pe_checker #(.ACC_W(ACC_W), .MAX_WIN(MAX_WIN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clear      (clear),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_last    (in_last),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_result (out_result)
);

// File: tb/tb_sqdiff_pe.sv
module tb_sqdiff_pe;
    localparam int unsigned OW = 8;
    localparam int unsigned MW = 4096;
    localparam int unsigned AW = sqd_pkg::acc_bits(OW, MW);

    logic                 clk = 1'b0;
    logic                 rst, clear, in_valid, in_ready, in_last;
    logic signed [OW-1:0] in_act, in_wgt;
    logic                 out_valid, out_ready;
    logic signed [AW-1:0] out_result;

    always #10 clk = ~clk;

    sqdiff_pe #(.OPND_W(OW), .MAX_WIN(MW)) dut (
        .clk(clk), .rst(rst), .clear(clear),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_act(in_act), .in_wgt(in_wgt), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result)
    );

    int     n_chk = 0;
    int     n_fail = 0;
    longint exp_q[$];
    string  tag_q[$];
    int     rdy_mode = 0;
    logic   rdy_manual = 1'b1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Downstream ready: 0 always high, 1 random, 2 manual
    initial begin
        out_ready = 1'b1;
        forever begin
            @(posedge clk); #1;
            case (rdy_mode)
                0:       out_ready = 1'b1;
                1:       out_ready = ($urandom % 3) != 0;
                default: out_ready = rdy_manual;
            endcase
        end
    end

    // Result monitor: compares against the reference queue, checks holds and stalls
    initial begin
        bit     held_v;
        longint held, r, e;
        string  t;
        held_v = 0; held = 0;
        forever begin
            @(negedge clk);
            if (!rst && out_valid) begin
                r = longint'(out_result);
                if (held_v) check(r == held, "R3", "result held under stall", r, held);
                if (!out_ready) begin
                    check(in_ready == 1'b0, "R4", "in_ready while result waits",
                          longint'(in_ready), 0);
                    held_v = 1; held = r;
                end else begin
                    held_v = 0;
                    check(r <= 0, "R10", "result sign", r, 0);
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R3", "result with no window", r, 0);
                    end else begin
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(r == e, t, "window result", r, e);
                    end
                end
            end else begin
                held_v = 0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "ALL", "watchdog expired", 0, 1);
        finish_up();
    end

    // Called at posedge+1; returns at posedge+1 after the beat is taken
    task automatic send_beat(input logic signed [OW-1:0] x, input logic signed [OW-1:0] w,
                             input bit last, input int gap);
        repeat (gap) begin
            in_valid = 1'b0; in_act = OW'($urandom); in_wgt = OW'($urandom);
            in_last = 1'($urandom);
            @(posedge clk); #1;
        end
        in_valid = 1'b1; in_act = x; in_wgt = w; in_last = last;
        forever begin
            @(negedge clk);
            if (in_ready) begin
                @(posedge clk); #1;
                break;
            end
            @(posedge clk); #1;
        end
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    // mode 0 random, 1 extreme alternating, 2 equal operands
    task automatic send_window(input int len, input int mode, input int max_gap,
                               input string tag);
        longint s, d, neg;
        logic signed [OW-1:0] x, w;
        s = 0;
        for (int k = 0; k < len; k++) begin
            case (mode)
                1: begin
                    x = (k % 2 == 0) ? -8'sd128 : 8'sd127;
                    w = (k % 2 == 0) ? 8'sd127 : -8'sd128;
                end
                2: begin x = OW'($urandom); w = x; end
                default: begin x = OW'($urandom); w = OW'($urandom); end
            endcase
            d = longint'(x) - longint'(w);
            s = s + d * d;
            if (k == len - 1) begin
                neg = -s;
                exp_q.push_back(neg >>> 1);
                tag_q.push_back(tag);
            end
            send_beat(x, w, k == len - 1, (max_gap > 0) ? int'($urandom % (max_gap + 1)) : 0);
        end
        @(negedge clk);
        check(out_valid == 1'b1, "R3", "valid one cycle after last", longint'(out_valid), 1);
        @(posedge clk); #1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; clear = 1'b0; in_valid = 1'b0; in_last = 1'b0;
        in_act = '0; in_wgt = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R9", "out_valid after reset", longint'(out_valid), 0);
        check(in_ready == 1'b1, "R9", "in_ready after reset", longint'(in_ready), 1);
        @(posedge clk); #1;

        // R2: single extreme beat, -32513
        send_window(1, 1, 0, "R2");
        // R1: zero differences give zero
        send_window(5, 2, 0, "R1");
        // R1: odd sum of one rounds down to -1
        exp_q.push_back(-1); tag_q.push_back("R1");
        send_beat(8'sd1, 8'sd0, 1'b1, 0);
        @(negedge clk); @(posedge clk); #1;
        send_window(9, 0, 0, "R1");

        // R5: partial window then clear, beat under clear not taken
        send_beat(8'sd100, -8'sd100, 1'b0, 0);
        send_beat(-8'sd50, 8'sd60, 1'b0, 0);
        clear = 1'b1; in_valid = 1'b1; in_act = 8'sd127; in_wgt = -8'sd128; in_last = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b0, "R5", "in_ready during clear", longint'(in_ready), 0);
        @(posedge clk); #1;
        clear = 1'b0; in_valid = 1'b0; in_last = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R5", "no result from beat under clear", longint'(out_valid), 0);
        @(posedge clk); #1;
        send_window(2, 1, 0, "R5");

        // R4: result held while downstream is not ready, next window waits
        rdy_mode = 2; rdy_manual = 1'b0;
        @(posedge clk); #1;
        send_window(3, 0, 0, "R4");
        fork
            send_window(2, 0, 0, "R4");
            begin repeat (6) @(posedge clk); #1 rdy_manual = 1'b1; end
        join
        rdy_mode = 0;

        // R7: back-to-back random windows under random back-pressure
        rdy_mode = 1;
        for (int i = 0; i < 15; i++) send_window(1 + int'($urandom % 40), 0, 0, "R7");
        // R8: idle cycles with junk on the inputs
        for (int i = 0; i < 15; i++) send_window(1 + int'($urandom % 40), 0, 3, "R8");
        rdy_mode = 0;

        // R6: longest window, every difference at full scale
        send_window(4096, 1, 0, "R6");

        while (exp_q.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
        finish_up();
    end
endmodule